// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block answers on a two-wire (I2C) bus as a small byte-addressed EEPROM. It watches SCL and SDA, which it samples with the system clock. It pulls SDA low through an output-enable when it acknowledges a byte or sends a zero data bit. A device-select byte carries a fixed 1010 prefix, three select bits and a direction bit. A write transaction carries a word address followed by data bytes. Those bytes collect in a page buffer and reach the storage array only when the master closes the transaction with a stop condition. A read transaction returns bytes from an internal pointer that advances after every byte the slave sends.

The parameter `KBIT4` picks the organisation. With 0 the block holds 256 bytes with 8-byte pages. With 1 it holds 512 bytes with 16-byte pages, and the lowest select bit becomes the ninth address bit. A write-protect input lets transactions run normally but stops the array from being updated.

Top module: `eep_i2c_slave`

## Requirements
- R1: A select byte whose top nibble is not 1010, or whose select bits differ from the straps being compared, gets no acknowledge (SDA stays high in the ninth clock). SDA then stays released for every following clock until the next start condition.
- R2: With `KBIT4`=1, select bits 3:2 are compared with straps A2 and A1, and select bit 1 is the array address bit 8. Bytes written with that bit at 1 and at 0 land in separate 256-byte halves, and strap A0 is not compared.
- R3: The slave drives SDA low in the ninth clock of every matched select byte, every word address byte and every data byte it receives.
- R4: Received data bytes reach the array only at a stop condition. A repeated start before the stop discards them, and the page buffer is empty after every start or stop.
- R5: Within a write, address bits below the page size (3 bits for 8-byte pages, 4 bits for 16-byte pages) advance after each data byte and wrap to 0 at the page end while the upper bits stay fixed. A later byte at the same page slot replaces the earlier one.
- R6: While `wp_i` is high at the stop condition, every byte of the write is still acknowledged but the array keeps its old contents.
- R7: Each byte sent in a read moves the pointer to that address plus one, modulo the array size, so a following current-address read starts there.
- R8: After a write of one or more data bytes, a current-address read starts at the last written address.
- R9: If the master pulls SDA low after a read byte, the next sequential byte follows, wrapping from the top address to 0. A high level ends the read, and SDA is released.
- R10: A write carrying only a word address, followed by a repeated start and a read select, returns data starting at that word address.
- R11: After reset SDA is released, the pointer is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data value to drive; always 0 (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_a2 | input | 1 | Address strap compared with select bit 3 |
| strap_a1 | input | 1 | Address strap compared with select bit 2 |
| strap_a0 | input | 1 | Address strap compared with select bit 1 (8-byte-page organisation only) |
| wp_i | input | 1 | Write protect; high blocks the commit at stop |

## Verification
Two things land on the same system-clock edge: the pointer advance at the end of a sent byte, and the fetch of the next byte of a sequential read. The fetch must use the advanced address, not the stale one. The bench provokes this with sequential reads that cross a page boundary and the top of the array, in both organisations. It judges each returned byte against a bench model that steps its own pointer by the requirements. The stop that commits a page is also interleaved with an immediate repeated start and with write protect, and the array is read back afterwards.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // select byte decode: prefix plus the strap bits that the organisation compares
  function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap,
                                     input logic kbit4);
    if (b[7:4] != DEV_CODE) return 1'b0;
    if (kbit4) return (b[3:2] == strap[2:1]);
    return (b[3:1] == strap);
  endfunction

  // full word address: block bit joins the received byte in the large organisation
  function automatic logic [8:0] addr_join(input logic blk, input logic [7:0] w,
                                           input logic kbit4);
    return kbit4 ? {blk, w} : {1'b0, w};
  endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, scl_s, scl_p, sda_m, sda_q, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_q <= sda_m; sda_p <= sda_q;
    end
  end

  assign sda_s     = sda_q;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BITS = 3,
  localparam int PAGE = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [PAGE_BITS-1:0] idx,
  input  logic [7:0]           wdata,
  output logic [PAGE*8-1:0]    data_flat,
  output logic [PAGE-1:0]      valid
);
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_flat[g*8 +: 8] <= 8'h00;
        valid[g]            <= 1'b0;
      end else if (clr) begin
        valid[g] <= 1'b0;
      end else if (we && (idx == PAGE_BITS'(g))) begin
        data_flat[g*8 +: 8] <= wdata;
        valid[g]            <= 1'b1;
      end
    end
  end

  // R4: nothing stays buffered past a start or stop
  p_buf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid == '0));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 3,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE  = 1 << PAGE_BITS,
  localparam int HI_W  = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [HI_W-1:0]   page_hi,
  input  logic [PAGE*8-1:0] data_flat,
  input  logic [PAGE-1:0]   valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (valid[i]) mem_q[{page_hi, PAGE_BITS'(i)}] <= data_flat[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter bit KBIT4 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe,
  input  logic strap_a2,
  input  logic strap_a1,
  input  logic strap_a0,
  input  logic wp_i
);
  localparam int ADDR_W    = KBIT4 ? 9 : 8;
  localparam int PAGE_BITS = KBIT4 ? 4 : 3;
  localparam int PAGE      = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - PAGE_BITS;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PAGE_BITS-1:0] page_off_next(input logic [PAGE_BITS-1:0] o);
    return o + 1'b1;
  endfunction

  // bus events
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e             state_q;
  logic [3:0]             bitcnt_q;
  logic [7:0]             shreg_q, txreg_q;
  logic                   sda_oe_q, ack_ok_q, rnw_q, blk_q, mack_q;
  logic [ADDR_W-1:0]      ptr_q;
  logic [HI_W-1:0]        page_hi_q;
  logic [PAGE_BITS-1:0]   wr_off_q;

  logic [PAGE*8-1:0]      buf_data;
  logic [PAGE-1:0]        buf_valid;
  logic [7:0]             rd_data;

  // named internal events
  logic                   rx_state, byte_in_done, dev_hit, buf_we, rd_advance;
  logic                   commit_fire, buf_clr;
  logic [7:0]             byte_in;
  logic [8:0]             waddr_full;
  logic [ADDR_W-1:0]      waddr, rd_addr;

  assign rx_state     = (state_q == ST_DEV) || (state_q == ST_WADDR) || (state_q == ST_WDATA);
  assign byte_in      = {shreg_q[6:0], sda_s};
  assign byte_in_done = rx_state && scl_rise && (bitcnt_q == 4'd7);
  assign dev_hit      = sel_match(byte_in, {strap_a2, strap_a1, strap_a0}, KBIT4);
  assign waddr_full   = addr_join(blk_q, byte_in, KBIT4);
  assign waddr        = waddr_full[ADDR_W-1:0];
  assign buf_we       = byte_in_done && (state_q == ST_WDATA);
  assign rd_advance   = (state_q == ST_READ) && scl_fall && (bitcnt_q == 4'd9);
  assign commit_fire  = stop_det && (|buf_valid) && !wp_i;
  assign buf_clr      = start_det || stop_det;
  assign rd_addr      = rd_advance ? seq_next(ptr_q) : ptr_q;

  eep_page_buf #(.PAGE_BITS(PAGE_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .idx(wr_off_q),
    .wdata(byte_in), .data_flat(buf_data), .valid(buf_valid)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_mem (
    .clk(clk), .rst_n(rst_n), .commit(commit_fire), .page_hi(page_hi_q),
    .data_flat(buf_data), .valid(buf_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      sda_oe_q  <= 1'b0;
      ack_ok_q  <= 1'b0;
      rnw_q     <= 1'b0;
      blk_q     <= 1'b0;
      mack_q    <= 1'b0;
      ptr_q     <= '0;
      page_hi_q <= '0;
      wr_off_q  <= '0;
    end else if (start_det) begin
      state_q  <= ST_DEV;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise) begin
        if (bitcnt_q < 4'd8) begin
          shreg_q  <= byte_in;
          bitcnt_q <= bitcnt_q + 1'b1;
        end else begin
          bitcnt_q <= 4'd9;
        end
        if (byte_in_done) begin
          unique case (state_q)
            ST_DEV: begin
              ack_ok_q <= dev_hit;
              rnw_q    <= byte_in[0];
              blk_q    <= byte_in[1];
              if (KBIT4 && dev_hit && byte_in[0]) ptr_q[ADDR_W-1] <= byte_in[1];
            end
            ST_WADDR: begin
              ack_ok_q  <= 1'b1;
              ptr_q     <= waddr;
              page_hi_q <= waddr[ADDR_W-1:PAGE_BITS];
              wr_off_q  <= waddr[PAGE_BITS-1:0];
            end
            default: begin
              ack_ok_q <= 1'b1;
              ptr_q    <= {page_hi_q, wr_off_q};
              wr_off_q <= page_off_next(wr_off_q);
            end
          endcase
        end
      end else if (scl_fall) begin
        if (bitcnt_q == 4'd8) begin
          sda_oe_q <= ack_ok_q;
          if (!ack_ok_q) state_q <= ST_IDLE;
        end else if (bitcnt_q == 4'd9) begin
          bitcnt_q <= '0;
          sda_oe_q <= 1'b0;
          if (state_q == ST_DEV) begin
            if (rnw_q) begin
              state_q  <= ST_READ;
              txreg_q  <= rd_data;
              sda_oe_q <= ~rd_data[7];
            end else begin
              state_q <= ST_WADDR;
            end
          end else begin
            state_q <= ST_WDATA;
          end
        end
      end
    end else if (state_q == ST_READ) begin
      if (scl_rise) begin
        if (bitcnt_q < 4'd8) bitcnt_q <= bitcnt_q + 1'b1;
        else begin
          mack_q   <= ~sda_s;
          bitcnt_q <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bitcnt_q == 4'd8) begin
          sda_oe_q <= 1'b0;
        end else if (bitcnt_q == 4'd9) begin
          ptr_q <= seq_next(ptr_q);
          if (mack_q) begin
            txreg_q  <= rd_data;
            sda_oe_q <= ~rd_data[7];
            bitcnt_q <= '0;
          end else begin
            state_q  <= ST_IDLE;
            sda_oe_q <= 1'b0;
          end
        end else if (bitcnt_q != 4'd0) begin
          txreg_q  <= {txreg_q[6:0], 1'b0};
          sda_oe_q <= ~txreg_q[6];
        end
      end
    end
  end

  assign sda_o  = 1'b0;
  assign sda_oe = sda_oe_q;

  // R1: an idle slave never holds the line
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_q);

  // R3: while receiving, SDA is only pulled in the acknowledge slot
  p_ack_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state && sda_oe_q) |-> (bitcnt_q >= 4'd8));

  // R5: a buffered byte never moves the pointer outside its page
  p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (ptr_q[ADDR_W-1:PAGE_BITS] == page_hi_q));

  // R7: each byte sent steps the pointer by one
  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_advance |=> (ptr_q == seq_next($past(ptr_q))));
endmodule

// File: tb/eep_i2c_slave_tb_top.sv
module eep_i2c_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic oe2, oe4, o2, o4;
  logic sda_line;
  int   n_chk = 0;
  int   n_bad = 0;
  logic [7:0] m2 [256];
  logic [7:0] m4 [512];
  int   ptr [2];

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~oe2 & ~oe4;

  eep_i2c_slave #(.KBIT4(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_o(o2), .sda_oe(oe2),
    .strap_a2(1'b0), .strap_a1(1'b0), .strap_a0(1'b0), .wp_i(wp));

  eep_i2c_slave #(.KBIT4(1'b1)) dut4_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_o(o4), .sda_oe(oe4),
    .strap_a2(1'b1), .strap_a1(1'b1), .strap_a0(1'b0), .wp_i(wp));

  function automatic int msize(input int dev); return dev ? 512 : 256; endfunction
  function automatic int pbits(input int dev); return dev ? 4 : 3; endfunction
  function automatic int pg_addr(input int a, input int pb, input int i);
    int mask = (1 << pb) - 1;
    return (a & ~mask) | ((a + i) & mask);
  endfunction
  function automatic logic [7:0] sel(input int dev, input int a, input bit rd);
    return dev ? {4'b1010, 2'b11, a[8], rd} : {4'b1010, 3'b000, rd};
  endfunction
  function automatic logic [7:0] getm(input int dev, input int a);
    return dev ? m4[a] : m2[a];
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (5) @(negedge clk); endtask

  task automatic start_c(); m_sda = 1'b1; q(); scl = 1'b1; q(); m_sda = 1'b0; q(); scl = 1'b0; q(); endtask
  task automatic stop_c(); m_sda = 1'b0; q(); scl = 1'b1; q(); m_sda = 1'b1; q(); endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0;
    end
    m_sda = 1'b1; q(); scl = 1'b1; q(); ack = !sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
    end
    m_sda = mack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); m_sda = 1'b1;
  endtask

  // read n bytes from the model pointer, NACK the last, check release, stop
  task automatic rd_bytes(input int dev, input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(b, getm(dev, ptr[dev]), tag);
      ptr[dev] = (ptr[dev] + 1) % msize(dev);
    end
    q();
    check(sda_line, 1, "R9 line released after NACK");
    stop_c();
  endtask

  task automatic cur_read(input int dev, input int n, input string tag);
    bit ack;
    start_c();
    send_byte(sel(dev, ptr[dev], 1'b1), ack);
    check(ack, 1, "R3 read select ack");
    rd_bytes(dev, n, tag);
  endtask

  task automatic rand_read(input int dev, input int a, input int n, input string tag);
    bit ack;
    start_c();
    send_byte(sel(dev, a, 1'b0), ack); check(ack, 1, "R3 select ack");
    send_byte(8'(a), ack);            check(ack, 1, "R3 word address ack");
    start_c();
    send_byte(sel(dev, a, 1'b1), ack); check(ack, 1, "R10 read select ack");
    ptr[dev] = a;
    rd_bytes(dev, n, tag);
  endtask

  // write n bytes from address a; end with stop (commit) or repeated start (discard)
  task automatic wr_txn(input int dev, input int a, input int n, input bit prot, input bit use_stop);
    bit ack;
    logic [7:0] d;
    logic [7:0] st_d [16];
    bit st_v [16];
    int pb = pbits(dev);
    int last = a;
    for (int i = 0; i < 16; i++) st_v[i] = 1'b0;
    wp = prot;
    start_c();
    send_byte(sel(dev, a, 1'b0), ack); check(ack, 1, "R3 select ack");
    send_byte(8'(a), ack);            check(ack, 1, "R3 word address ack");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      last = pg_addr(a, pb, i);
      st_d[last & ((1 << pb) - 1)] = d;
      st_v[last & ((1 << pb) - 1)] = 1'b1;
      send_byte(d, ack);
      check(ack, 1, prot ? "R6 data ack under protect" : "R3 data ack");
    end
    if (!use_stop) start_c();
    stop_c();
    q();
    wp = 1'b0;
    if (use_stop && !prot) begin
      for (int i = 0; i < 16; i++) begin
        if (st_v[i]) begin
          if (dev) m4[(a & ~((1 << pb) - 1)) | i] = st_d[i];
          else     m2[(a & ~((1 << pb) - 1)) | i] = st_d[i];
        end
      end
    end
    ptr[dev] = last;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit ack;
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) m2[i] = 8'hFF;
    for (int i = 0; i < 512; i++) m4[i] = 8'hFF;
    ptr[0] = 0; ptr[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    q();
    check(oe2, 0, "R11 reset releases SDA (small)");
    check(oe4, 0, "R11 reset releases SDA (large)");
    cur_read(0, 2, "R11 erased array from pointer 0");
    cur_read(1, 1, "R11 erased array large");

    // byte write then random read
    wr_txn(0, 8'h10, 1, 1'b0, 1'b1);
    rand_read(0, 8'h10, 1, "R10 random read of written byte");
    // pointer stays on last written byte, then steps after reads
    wr_txn(0, 8'h20, 1, 1'b0, 1'b1);
    cur_read(0, 1, "R8 current read at last written address");
    cur_read(0, 1, "R7 current read after read is next address");
    wr_txn(0, 8'h33, 3, 1'b0, 1'b1);
    cur_read(0, 1, "R8 current read after page write");

    // page wrap and overwrite
    wr_txn(0, 8'h2D, 5, 1'b0, 1'b1);
    rand_read(0, 8'h28, 8, "R5 eight-byte page wrap");
    wr_txn(0, 8'h4A, 11, 1'b0, 1'b1);
    rand_read(0, 8'h48, 8, "R5 overflow overwrites page");

    // repeated start discards
    wr_txn(0, 8'h60, 3, 1'b0, 1'b0);
    rand_read(0, 8'h60, 3, "R4 repeated start discards data");

    // write protect
    wr_txn(0, 8'h70, 4, 1'b1, 1'b1);
    rand_read(0, 8'h70, 4, "R6 protected write leaves array");

    // select mismatch, both devices silent afterwards
    start_c();
    send_byte(8'b1010_0010, ack); check(ack, 0, "R1 mismatched select not acknowledged");
    send_byte(8'h00, ack);        check(ack, 0, "R1 SDA released until next start");
    stop_c();
    start_c();
    send_byte(8'b1011_0000, ack); check(ack, 0, "R1 wrong prefix not acknowledged");
    stop_c();
    start_c();
    send_byte(8'b1010_1010, ack); check(ack, 0, "R1 large strap A1 mismatch");
    stop_c();

    // large organisation: block bit and 16-byte pages
    wr_txn(1, 9'h1F3, 3, 1'b0, 1'b1);
    wr_txn(1, 9'h0F3, 3, 1'b0, 1'b1);
    rand_read(1, 9'h1F3, 3, "R2 upper block contents");
    rand_read(1, 9'h0F3, 3, "R2 lower block contents");
    wr_txn(1, 9'h10E, 4, 1'b0, 1'b1);
    rand_read(1, 9'h100, 16, "R5 sixteen-byte page wrap");
    wr_txn(1, 9'h155, 2, 1'b0, 1'b1);
    cur_read(1, 2, "R8 large current read at last written");

    // sequential reads across page and array ends
    rand_read(0, 8'hFD, 5, "R9 sequential read wraps array (small)");
    rand_read(1, 9'h1FE, 4, "R9 sequential read wraps array (large)");
    rand_read(1, 9'h0FE, 4, "R9 sequential read crosses block");
    cur_read(1, 1, "R7 pointer after sequential read");

    // mixed random traffic
    for (int k = 0; k < 24; k++) begin
      int dev = $urandom % 2;
      int op  = $urandom % 3;
      int a   = $urandom % msize(dev);
      if (op == 0) wr_txn(dev, a, 1 + ($urandom % 10), ($urandom % 4) == 0, 1'b1);
      else if (op == 1) rand_read(dev, a, 1 + ($urandom % 4), "R10 random read mixed");
      else cur_read(dev, 1 + ($urandom % 3), "R7 current read mixed");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule